// File: doc/BRIEF.md
# Cache Control and Tag-Clear Sequencer

This block holds the software-visible controls of a small cache and runs the sequence that empties it. Three registers sit behind a simple 32-bit register bus. A settings register holds a clear request and two global enables, one for data fills and one for instruction fills. A status register shows whether a tag clear is running. A page mask register holds one enable bit for each of 16 address pages.

When software sets the clear request, the block walks the whole tag store, one entry per clock cycle. On each of those cycles it drives a write strobe, the entry index and an invalid tag value. The busy flag in the status register stays high until the last entry has been written. Software polls that flag before it enables the cache.

For each cache access the block also gives a verdict: whether a data fill and whether an instruction fill may allocate a line. The verdict combines the matching global enable, the page mask bit selected by the access address, and the absence of a running clear.

Top module: `cache_ctrl_top`

## Requirements
- R1: After reset, the status, settings and page mask registers all read 0, no tag write strobe is driven, and both allocate outputs are 0.
- R2: The status register is at offset 0x000, settings at 0x004 and the page mask at 0x008. Any other offset reads 0, and writes to it change nothing. Writes to the status register are ignored.
- R3: Reserved bits read as 0: status bits 31:1, settings bits 31:3 and page mask bits 31:16.
- R4: A write that moves settings bit 0 from 0 to 1 while no clear is running starts a clear. From the next cycle, status bit 0 reads 1 and the tag write strobe is high with index 0.
- R5: A clear drives the tag write strobe on 128 consecutive cycles. The indices run 0, 1, …, 127, so each entry is written exactly once, and the tag value output is 0 (invalid) on every one of those cycles.
- R6: Status bit 0 and the strobe fall on the cycle right after the cycle that carries index 127. A clear therefore occupies exactly 128 cycles.
- R7: A clear request written while a clear is running neither restarts nor extends that clear.
- R8: The data allocate output equals settings bit 1 AND the page mask bit of the access page AND NOT busy.
- R9: The instruction allocate output equals settings bit 2 AND the page mask bit of the access page AND NOT busy.
- R10: The access page is address bits [15:12] (PAGE_LSB+3 : PAGE_LSB, with PAGE_LSB = 12). No other address bit affects the allocate outputs.
- R11: Writing settings bit 0 back to 0 during a clear does not abort it. The clear still runs its full 128 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access select |
| reg_we | input | 1 | Write strobe for the register bus |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| acc_addr | input | 32 | Address of the current cache access |
| data_alloc_ok | output | 1 | Data fill may allocate for acc_addr |
| instr_alloc_ok | output | 1 | Instruction fill may allocate for acc_addr |
| tag_clr_we | output | 1 | Tag store write strobe during a clear |
| tag_clr_idx | output | 7 | Tag entry index being cleared |
| tag_clr_vld | output | 1 | Valid bit written into the tag entry (always 0) |

## Verification
Several properties are checked on every cycle. A started clear begins at index 0 on the next cycle. Its index steps by exactly one while the strobe stays high. The strobe falls only after index 127 and never drops out early, even when the request bit is cleared. Neither allocate output is ever high while the strobe is active. Other behaviour can only be shown by the bench's scenarios, because each depends on a particular write sequence or on read values:
- that every entry is written exactly once;
- that the busy flag takes exactly 128 cycles;
- the register offsets and the reserved bits reading as 0;
- the allocate outputs across combinations of enables, mask and page.

// File: rtl/cache_ctl_pkg.sv
package cache_ctl_pkg;

    localparam int REG_DW      = 32;
    localparam int OFS_STATUS  = 'h000;
    localparam int OFS_SETTING = 'h004;
    localparam int OFS_PGMASK  = 'h008;

    // Settings register layout: bit 2 instr enable, bit 1 data enable, bit 0 clear request
    typedef struct packed {
        logic instr_en;
        logic data_en;
        logic clr_req;
    } settings_t;

    localparam int SETTINGS_W = $bits(settings_t);

    function automatic logic [REG_DW-1:0] status_word(input logic busy);
        return {{(REG_DW-1){1'b0}}, busy};
    endfunction

endpackage

// File: rtl/cc_regs.sv
module cc_regs
    import cache_ctl_pkg::*;
#(
    parameter int REG_AW = 12,
    parameter int PAGES  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              clr_busy,
    output settings_t         cfg,
    output logic [PAGES-1:0]  page_mask,
    output logic              clr_start
);

    localparam logic [REG_AW-1:0] A_STAT = REG_AW'(OFS_STATUS);
    localparam logic [REG_AW-1:0] A_SET  = REG_AW'(OFS_SETTING);
    localparam logic [REG_AW-1:0] A_MASK = REG_AW'(OFS_PGMASK);

    settings_t        cfg_q;
    logic [PAGES-1:0] mask_q;
    logic             wr_set;
    logic             wr_mask;
    logic             unused_wdata;

    assign wr_set  = reg_en && reg_we && (reg_addr == A_SET);
    assign wr_mask = reg_en && reg_we && (reg_addr == A_MASK);

    // A new request only starts when the bit rises and the sequencer is idle
    assign clr_start = wr_set && reg_wdata[0] && !cfg_q.clr_req && !clr_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            mask_q <= '0;
        end else begin
            if (wr_set) begin
                cfg_q <= settings_t'(reg_wdata[SETTINGS_W-1:0]);
            end
            if (wr_mask) begin
                mask_q <= reg_wdata[PAGES-1:0];
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_STAT:  reg_rdata = status_word(clr_busy);
            A_SET:   reg_rdata = REG_DW'(cfg_q);
            A_MASK:  reg_rdata = REG_DW'(mask_q);
            default: reg_rdata = '0;
        endcase
    end

    assign unused_wdata = ^reg_wdata;
    assign cfg          = cfg_q;
    assign page_mask    = mask_q;

endmodule

// File: rtl/cc_clr_seq.sv
module cc_clr_seq #(
    parameter int ENTRIES = 128,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_start,
    output logic             busy,
    output logic             tag_we,
    output logic [IDX_W-1:0] tag_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic             busy_q;
    logic [IDX_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (clr_start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy    = busy_q;
    assign tag_we  = busy_q;
    assign tag_idx = cnt_q;

endmodule

// File: rtl/cc_alloc_gate.sv
module cc_alloc_gate
    import cache_ctl_pkg::*;
#(
    parameter int ACC_AW   = 32,
    parameter int PAGE_LSB = 12,
    parameter int PAGES    = 16,
    parameter int PAGE_W   = $clog2(PAGES)
) (
    input  settings_t         cfg,
    input  logic [PAGES-1:0]  page_mask,
    input  logic              busy,
    input  logic [ACC_AW-1:0] acc_addr,
    output logic              data_ok,
    output logic              instr_ok
);

    logic [PAGE_W-1:0] page;
    logic              page_on;
    logic              unused_addr;

    assign page        = acc_addr[PAGE_LSB +: PAGE_W];
    assign page_on     = page_mask[page] && !busy;
    assign data_ok     = cfg.data_en  && page_on;
    assign instr_ok    = cfg.instr_en && page_on;
    assign unused_addr = ^{acc_addr, cfg.clr_req};

endmodule

// File: rtl/cache_ctrl_top.sv
module cache_ctrl_top
    import cache_ctl_pkg::*;
#(
    parameter int REG_AW      = 12,
    parameter int ACC_AW      = 32,
    parameter int PAGE_LSB    = 12,
    parameter int PAGES       = 16,
    parameter int TAG_ENTRIES = 128,
    parameter int IDX_W       = $clog2(TAG_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [ACC_AW-1:0] acc_addr,
    output logic              data_alloc_ok,
    output logic              instr_alloc_ok,
    output logic              tag_clr_we,
    output logic [IDX_W-1:0]  tag_clr_idx,
    output logic              tag_clr_vld
);

    settings_t        cfg;
    logic [PAGES-1:0] page_mask;
    logic             clr_start;
    logic             clr_busy;

    cc_regs #(.REG_AW(REG_AW), .PAGES(PAGES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .clr_busy  (clr_busy),
        .cfg       (cfg),
        .page_mask (page_mask),
        .clr_start (clr_start)
    );

    cc_clr_seq #(.ENTRIES(TAG_ENTRIES), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .clr_start (clr_start),
        .busy      (clr_busy),
        .tag_we    (tag_clr_we),
        .tag_idx   (tag_clr_idx)
    );

    cc_alloc_gate #(.ACC_AW(ACC_AW), .PAGE_LSB(PAGE_LSB), .PAGES(PAGES)) u_gate (
        .cfg       (cfg),
        .page_mask (page_mask),
        .busy      (clr_busy),
        .acc_addr  (acc_addr),
        .data_ok   (data_alloc_ok),
        .instr_ok  (instr_alloc_ok)
    );

    assign tag_clr_vld = 1'b0;

endmodule

// File: rtl/cc_checker.sv
module cc_checker #(
    parameter int ENTRIES = 128,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_start,
    input logic             tag_clr_we,
    input logic [IDX_W-1:0] tag_clr_idx,
    input logic             data_alloc_ok,
    input logic             instr_alloc_ok
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // R4
    start_first_idx_chk: assert property (@(posedge clk) disable iff (rst)
        clr_start |=> (tag_clr_we && tag_clr_idx == '0));

    // R5
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tag_clr_we && $past(tag_clr_we)) |-> (tag_clr_idx == IDX_W'($past(tag_clr_idx) + 1'b1)));

    // R6
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tag_clr_we) |-> ($past(tag_clr_idx) == LAST));

    // R11
    no_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (tag_clr_we && tag_clr_idx != LAST) |=> tag_clr_we);

    // R8
    data_gate_chk: assert property (@(posedge clk) disable iff (rst)
        data_alloc_ok |-> !tag_clr_we);

    // R9
    instr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        instr_alloc_ok |-> !tag_clr_we);

endmodule

bind cache_ctrl_top cc_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .clr_start      (clr_start),
    .tag_clr_we     (tag_clr_we),
    .tag_clr_idx    (tag_clr_idx),
    .data_alloc_ok  (data_alloc_ok),
    .instr_alloc_ok (instr_alloc_ok)
);

// File: tb/test_cache_ctrl_top.sv
module test_cache_ctrl_top;

    localparam int CLK_NS = 8;
    localparam int NVEC   = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_en;
    logic        reg_we;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [31:0] acc_addr;
    logic        data_alloc_ok;
    logic        instr_alloc_ok;
    logic        tag_clr_we;
    logic [6:0]  tag_clr_idx;
    logic        tag_clr_vld;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    int hits [128];
    int strobes;
    int vld_bad;

    always #(CLK_NS / 2) clk = ~clk;

    cache_ctrl_top i_cache_ctrl_top (
        .clk            (clk),
        .rst            (rst),
        .reg_en         (reg_en),
        .reg_we         (reg_we),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .acc_addr       (acc_addr),
        .data_alloc_ok  (data_alloc_ok),
        .instr_alloc_ok (instr_alloc_ok),
        .tag_clr_we     (tag_clr_we),
        .tag_clr_idx    (tag_clr_idx),
        .tag_clr_vld    (tag_clr_vld)
    );

    // strobe monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst && tag_clr_we) begin
            hits[tag_clr_idx] = hits[tag_clr_idx] + 1;
            strobes = strobes + 1;
            if (tag_clr_vld !== 1'b0) vld_bad = vld_bad + 1;
        end
    end

    // {settings[2:0], mask[15:0], page[3:0], exp_data, exp_instr}
    localparam logic [24:0] VEC [NVEC] = '{
        {3'b010, 16'h0001, 4'd0,  1'b1, 1'b0},
        {3'b100, 16'h0001, 4'd0,  1'b0, 1'b1},
        {3'b110, 16'h0001, 4'd1,  1'b0, 1'b0},
        {3'b110, 16'h8000, 4'd15, 1'b1, 1'b1},
        {3'b000, 16'hFFFF, 4'd7,  1'b0, 1'b0},
        {3'b110, 16'h0000, 4'd3,  1'b0, 1'b0},
        {3'b010, 16'h00A0, 4'd5,  1'b1, 1'b0},
        {3'b100, 16'h00A0, 4'd6,  1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // called at a negedge; consumes one cycle
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_en    = 1'b1;
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_en    = 1'b0;
        reg_we    = 1'b0;
        reg_addr  = 12'h000;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 12'h000;
    endtask

    task automatic clear_hits();
        for (int i = 0; i < 128; i++) hits[i] = 0;
        strobes = 0;
        vld_bad = 0;
    endtask

    task automatic check_hits(input string req);
        int bad;
        bad = 0;
        for (int i = 0; i < 128; i++) if (hits[i] != 1) bad = bad + 1;
        check(bad == 0, req, bad, 0);
        check(strobes == 128, req, strobes, 128);
        check(vld_bad == 0, req, vld_bad, 0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            failures = failures + 1;
            checks   = checks + 1;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int          cyc;
        bit          seq_ok;
        bit          gate_ok;
        rst = 1'b1; reg_en = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        acc_addr = 32'h0000_0000;
        clear_hits();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(12'h000, v); check(v == 0, "R1 status", v, 0);
        rd(12'h004, v); check(v == 0, "R1 settings", v, 0);
        rd(12'h008, v); check(v == 0, "R1 page mask", v, 0);
        check({tag_clr_we, data_alloc_ok, instr_alloc_ok} == 3'b000, "R1 outputs",
              {tag_clr_we, data_alloc_ok, instr_alloc_ok}, 0);

        // R8 R9 R10 vector table
        for (int n = 0; n < NVEC; n++) begin
            wr(12'h004, {29'h0, VEC[n][24:22]});
            wr(12'h008, {16'h0, VEC[n][21:6]});
            acc_addr = 32'hABC0_05A4 | ({28'h0, VEC[n][5:2]} << 12);
            #1;
            check(data_alloc_ok == VEC[n][1], "R8 data allocate", data_alloc_ok, VEC[n][1]);
            check(instr_alloc_ok == VEC[n][0], "R9 instr allocate", instr_alloc_ok, VEC[n][0]);
            @(negedge clk);
        end

        // R10 only bits 15:12 select the page
        wr(12'h004, 32'h6);
        wr(12'h008, 32'h0000_0010);
        acc_addr = 32'hFFFE_4FFF; #1;
        check(data_alloc_ok && instr_alloc_ok, "R10 page 4 set", {data_alloc_ok, instr_alloc_ok}, 3);
        acc_addr = 32'h0001_3000; #1;
        check(!data_alloc_ok && !instr_alloc_ok, "R10 page 3 clear", {data_alloc_ok, instr_alloc_ok}, 0);
        @(negedge clk);

        // R3 reserved bits
        wr(12'h008, 32'hFFFF_FFFF);
        rd(12'h008, v); check(v == 32'h0000_FFFF, "R3 mask reserved", v, 32'h0000_FFFF);
        wr(12'h004, 32'hFFFF_FFF6);
        rd(12'h004, v); check(v == 32'h6, "R3 settings reserved", v, 6);

        // R2 offsets
        wr(12'h00C, 32'hFFFF_FFFF);
        rd(12'h00C, v); check(v == 0, "R2 unmapped read", v, 0);
        rd(12'h004, v); check(v == 32'h6, "R2 settings untouched", v, 6);
        rd(12'h008, v); check(v == 32'h0000_FFFF, "R2 mask untouched", v, 32'h0000_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, v); check(v == 0, "R2 status read-only", v, 0);
        check(!tag_clr_we, "R2 status write starts nothing", tag_clr_we, 0);

        // R4 R5 R6 R8 R9 first clear
        acc_addr = 32'h0000_9000;
        clear_hits();
        wr(12'h004, 32'h7);
        rd(12'h000, v); check(v == 1, "R4 status busy", v, 1);
        seq_ok = 1'b1; gate_ok = 1'b1;
        for (int k = 0; k < 128; k++) begin
            if (!tag_clr_we || tag_clr_idx != 7'(k)) seq_ok = 1'b0;
            if (data_alloc_ok || instr_alloc_ok) gate_ok = 1'b0;
            @(negedge clk);
        end
        check(seq_ok, "R5 index order", seq_ok, 1);
        check(gate_ok, "R8 R9 allocate held off while busy", gate_ok, 1);
        rd(12'h000, v); check(v == 0, "R6 status falls after index 127", v, 0);
        check(!tag_clr_we, "R6 strobe low", tag_clr_we, 0);
        check_hits("R5 each entry once");
        check(data_alloc_ok && instr_alloc_ok, "R8 R9 allocate after clear",
              {data_alloc_ok, instr_alloc_ok}, 3);

        // R7 R11 second clear with writes while running
        clear_hits();
        wr(12'h004, 32'h6);
        wr(12'h004, 32'h7);
        cyc = 0;
        repeat (29) begin @(negedge clk); cyc++; end
        wr(12'h004, 32'h6); cyc++;   // R11 drop request
        repeat (29) begin @(negedge clk); cyc++; end
        wr(12'h004, 32'h7); cyc++;   // R7 re-request while busy
        rd(12'h000, v);
        while (v[0] && cyc < 1000) begin
            @(negedge clk); cyc++;
            rd(12'h000, v);
        end
        check(cyc == 128, "R7 R11 clear length", cyc, 128);
        check_hits("R7 R11 each entry once");
        repeat (4) @(negedge clk);
        check(!tag_clr_we, "R7 no late restart", tag_clr_we, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule